// File: doc/BRIEF.md
# Chaotic-Stage Random Bit Extractor

This block is the digital back-end of a random bit source whose analog part is a ring of redundant one-and-a-half-bit converter stages fed back on themselves. Every sampling step each of the eight stages presents a two-bit comparator reading in thermometer form. The block reduces each reading to one raw bit by an exclusive-OR of the two comparator bits, and packs the eight lane bits into a byte. Bit k of the byte always comes from stage k.

A trajectory started from a known state stays predictable for its first few iterations. For that reason, after reset the block discards a fixed number of input words before it raises any output. In an optional compressed mode, each lane folds four consecutive accepted raw bits into their parity. This yields one output byte per four input words. A sticky flag reports any comparator pair that shows the code the thermometer form forbids.

Top module: `chaos_bit_extractor`

## Requirements
- R1: The raw bit of lane k is cmp_hi_i[k] XOR cmp_lo_i[k], and it lands in bit k of the output byte.
- R2: With par_en_i low, every accepted input word yields valid_o high on the next cycle, with data_o equal to that word's raw byte.
- R3: The first WARM_WORDS input words after reset (16 by default) are discarded. valid_o stays low through the cycle after the last discarded word.
- R4: With par_en_i high, accepted words are grouped in fours. valid_o is high for one cycle after the fourth word of a group, with data_o equal to the XOR of the four raw bytes. valid_o is low after the other three words.
- R5: data_o changes only in a cycle where valid_o is high, and otherwise holds the last emitted byte.
- R6: A lane reading with cmp_hi_i=1 and cmp_lo_i=0 (the illegal thermometer code) sets illegal_o on the next cycle. The flag then stays high until reset. The legal codes {hi,lo} = 00, 01 and 11 never set it.
- R7: While rst_ni is low, valid_o, data_o and illegal_o are 0, and the warm-up count, group counters and parity state are cleared.
- R8: Any accepted word taken with par_en_i low empties the partial parity group. After par_en_i is raised again, a new group starts with the next accepted word.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Step clock, one input word per rising edge |
| rst_ni | input | 1 | Asynchronous active-low reset |
| cmp_lo_i | input | 8 | Lower comparator bit of each stage |
| cmp_hi_i | input | 8 | Upper comparator bit of each stage |
| par_en_i | input | 1 | Selects four-to-one parity compression |
| valid_o | output | 1 | Output byte strobe |
| data_o | output | 8 | Output byte, bit k from stage k |
| illegal_o | output | 1 | Sticky illegal thermometer code flag |

## Verification
A warm-up counter that is off by one shows up as a strobe one word early or late, on the first output after reset. A lane group counter that drifts breaks the lockstep between lanes. That produces a wrong byte, or a strobe in the wrong cycle, within four accepted words. A parity register that fails to clear after a group or a mode change corrupts the very next compressed byte. A flag that does not stick drops back to zero one cycle after a clean word.

// File: rtl/cbx_pkg.sv
package cbx_pkg;
  // {hi,lo} comparator reading
  typedef enum logic [1:0] {
    TC_LOW  = 2'b00,
    TC_MID  = 2'b01,
    TC_BAD  = 2'b10,
    TC_HIGH = 2'b11
  } therm_code_e;
endpackage

// File: rtl/cbx_warmup.sv
module cbx_warmup #(
  parameter int unsigned WARM_WORDS = 16
) (
  input  logic clk_i,
  input  logic rst_ni,
  output logic done_o
);
  localparam int unsigned CW = $clog2(WARM_WORDS + 2);
  localparam logic [CW-1:0] LIMIT = CW'(WARM_WORDS);

  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)              cnt_q <= '0;
    else if (cnt_q != LIMIT)  cnt_q <= cnt_q + 1'b1;
  end

  assign done_o = (cnt_q == LIMIT);

  AST_WARM_MONOTONIC: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> done_o); // R3
endmodule

// File: rtl/cbx_lane.sv
module cbx_lane
  import cbx_pkg::*;
#(
  parameter int unsigned GROUP = 4
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic lo_i,
  input  logic hi_i,
  input  logic take_i,
  input  logic par_en_i,
  output logic raw_o,
  output logic par_o,
  output logic emit_o,
  output logic bad_o
);
  localparam int unsigned CNT_W = (GROUP > 1) ? $clog2(GROUP) : 1;
  localparam logic [CNT_W-1:0] LAST = CNT_W'(GROUP - 1);

  logic [CNT_W-1:0] cnt_q;
  logic             acc_q;

  assign raw_o  = hi_i ^ lo_i;
  assign bad_o  = (therm_code_e'({hi_i, lo_i}) == TC_BAD);
  assign emit_o = take_i && par_en_i && (cnt_q == LAST);
  assign par_o  = acc_q ^ raw_o;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= '0;
      acc_q <= 1'b0;
    end else if (take_i) begin
      if (!par_en_i || emit_o) begin
        cnt_q <= '0;
        acc_q <= 1'b0;
      end else begin
        cnt_q <= cnt_q + 1'b1;
        acc_q <= par_o;
      end
    end
  end

  AST_RAW_MODE_EMPTY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (take_i && !par_en_i) |=> !emit_o); // R8
endmodule

// File: rtl/chaos_bit_extractor.sv
module chaos_bit_extractor #(
  parameter int unsigned LANES      = 8,
  parameter int unsigned WARM_WORDS = 16,
  parameter int unsigned GROUP      = 4
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [LANES-1:0] cmp_lo_i,
  input  logic [LANES-1:0] cmp_hi_i,
  input  logic             par_en_i,
  output logic             valid_o,
  output logic [LANES-1:0] data_o,
  output logic             illegal_o
);
  logic             take;
  logic [LANES-1:0] raw_bits, par_bits, emit, bad;

  cbx_warmup #(.WARM_WORDS(WARM_WORDS)) u_warmup (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .done_o (take)
  );

  for (genvar k = 0; k < LANES; k++) begin : g_lane
    cbx_lane #(.GROUP(GROUP)) u_lane (
      .clk_i    (clk_i),
      .rst_ni   (rst_ni),
      .lo_i     (cmp_lo_i[k]),
      .hi_i     (cmp_hi_i[k]),
      .take_i   (take),
      .par_en_i (par_en_i),
      .raw_o    (raw_bits[k]),
      .par_o    (par_bits[k]),
      .emit_o   (emit[k]),
      .bad_o    (bad[k])
    );
  end

  logic fire;
  assign fire = take && (par_en_i ? emit[0] : 1'b1);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      valid_o   <= 1'b0;
      data_o    <= '0;
      illegal_o <= 1'b0;
    end else begin
      valid_o   <= fire;
      if (fire) data_o <= par_en_i ? par_bits : raw_bits;
      illegal_o <= illegal_o | (|bad);
    end
  end

  AST_WARM_SILENT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !take |=> !valid_o); // R3
  AST_LANES_LOCKSTEP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (|emit) |-> (&emit)); // R4
  AST_DATA_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !valid_o |-> $stable(data_o)); // R5
  AST_FLAG_STICKY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    illegal_o |=> illegal_o); // R6
  AST_FLAG_SET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (|(cmp_hi_i & ~cmp_lo_i)) |=> illegal_o); // R6
endmodule

// File: tb/chaos_bit_extractor_bench.sv
module chaos_bit_extractor_bench;
  localparam int WARM = 16;

  logic       clk = 1'b0;
  logic       rst_ni = 1'b0;
  logic [7:0] lo = '0, hi = '0;
  logic       par = 1'b0;
  logic       valid;
  logic [7:0] data;
  logic       illegal;

  int checks = 0, failures = 0;

  // reference model state
  int         m_words = 0;
  int         m_cnt = 0;
  logic [7:0] m_acc = '0;
  logic       e_valid = 1'b0;
  logic [7:0] e_data = '0;
  logic       e_ill = 1'b0;

  always #2 clk = ~clk;

  chaos_bit_extractor u_chaos_bit_extractor (
    .clk_i(clk), .rst_ni(rst_ni), .cmp_lo_i(lo), .cmp_hi_i(hi),
    .par_en_i(par), .valid_o(valid), .data_o(data), .illegal_o(illegal)
  );

  function automatic logic [7:0] raw_of(logic [7:0] h, logic [7:0] l);
    return h ^ l;
  endfunction

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic check_outputs(string req);
    chk({req, " valid"}, 32'(valid), 32'(e_valid));
    chk({req, " data"}, 32'(data), 32'(e_data));
    chk("R6 flag", 32'(illegal), 32'(e_ill));
  endtask

  // drive one word at negedge, update model for the coming edge, check after it
  task automatic step(logic [7:0] h, logic [7:0] l, logic p, string req);
    logic [7:0] r;
    hi = h; lo = l; par = p;
    r = raw_of(h, l);
    e_ill = e_ill | (|(h & ~l));
    if (m_words >= WARM) begin
      if (p) begin
        m_acc ^= r;
        m_cnt++;
        if (m_cnt == 4) begin
          e_valid = 1'b1; e_data = m_acc; m_acc = '0; m_cnt = 0;
        end else e_valid = 1'b0;
      end else begin
        m_acc = '0; m_cnt = 0;
        e_valid = 1'b1; e_data = r;
      end
    end else e_valid = 1'b0;
    m_words++;
    @(negedge clk);
    check_outputs(req);
  endtask

  task automatic rand_word(output logic [7:0] h, output logic [7:0] l);
    for (int k = 0; k < 8; k++) begin
      case ($urandom % 3)
        0: begin h[k] = 1'b0; l[k] = 1'b0; end
        1: begin h[k] = 1'b0; l[k] = 1'b1; end
        default: begin h[k] = 1'b1; l[k] = 1'b1; end
      endcase
    end
  endtask

  task automatic do_reset();
    rst_ni = 1'b0;
    m_words = 0; m_cnt = 0; m_acc = '0;
    e_valid = 1'b0; e_data = '0; e_ill = 1'b0;
    @(negedge clk);
    check_outputs("R7 reset");
    rst_ni = 1'b1;
  endtask

  initial begin
    #800000;
    failures++;
    $display("FAIL watchdog actual=running expected=done");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    logic [7:0] h, l;
    void'($urandom(32'h5eed_1234));
    @(negedge clk);
    do_reset();
    // R3: warm-up words, all producing raw ones, must be dropped
    for (int i = 0; i < WARM; i++) step(8'h00, 8'hFF, 1'b0, "R3 warmup");
    // R1/R2 directed codes
    step(8'h00, 8'hFF, 1'b0, "R1 all mid");
    step(8'hFF, 8'hFF, 1'b0, "R1 all high");
    step(8'h00, 8'h00, 1'b0, "R1 all low");
    step(8'h00, 8'hA5, 1'b0, "R1 lane pattern");
    for (int i = 0; i < 40; i++) begin
      rand_word(h, l); step(h, l, 1'b0, "R2 raw random");
    end
    // R4 parity mode
    for (int i = 0; i < 40; i++) begin
      rand_word(h, l); step(h, l, 1'b1, "R4 parity");
    end
    // R8: break a group with a raw word, then resume
    for (int i = 0; i < 2; i++) begin
      rand_word(h, l); step(h, l, 1'b1, "R8 partial");
    end
    rand_word(h, l); step(h, l, 1'b0, "R8 raw break");
    for (int i = 0; i < 8; i++) begin
      rand_word(h, l); step(h, l, 1'b1, "R8 regroup");
    end
    // R5 hold between strobes with changing inputs
    for (int i = 0; i < 12; i++) begin
      rand_word(h, l); step(h, l, 1'b1, "R5 hold");
    end
    // reset mid-stream in parity mode, warm-up again
    do_reset();
    for (int i = 0; i < WARM + 12; i++) begin
      rand_word(h, l); step(h, l, 1'b1, "R3 rewarm parity");
    end
    // R6 illegal code on one lane, then clean words
    step(8'h10, 8'h00, 1'b0, "R6 inject");
    for (int i = 0; i < 6; i++) begin
      rand_word(h, l); step(h, l, 1'b0, "R6 sticky");
    end
    do_reset();
    chk("R7 flag cleared", 32'(illegal), 32'd0);
    for (int i = 0; i < 4; i++) begin
      rand_word(h, l); step(h, l, 1'b0, "R7 after reset");
    end
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule